// File: doc/BRIEF.md
# Two-Wire Bus Recovery Line Override Sequencer

This block frees a two-wire serial bus when a slave device is stuck holding the data line low, typically because the controller was reset in the middle of a transfer. It owns a small control register that software can write to force the clock line or the data line low through open-drain pads, and which also holds the core interrupt enable. When the recovery trigger is raised, the block takes over both override lines. It toggles the clock line nine times, then builds a stop condition by hand, and finally releases both lines. It signals the end with a one-cycle done pulse.

The intended use is after a start request fails to leave the idle status. Control logic triggers this sequencer, waits for done and then retries the start. Each step of the sequence lasts a programmable number of system clock cycles, chosen to be about half a bus clock period. While the sequence runs, software writes to the two override bits are discarded. Writes to the interrupt enable are still accepted.

Top module: `twl_unstick`

## Requirements
- R1: After reset both override outputs are low (lines released), the interrupt enable output is low, done is low and the register reads as zero.
- R2: When idle, a register write stores bit 9 (force clock low), bit 8 (force data low) and bit 6 (interrupt enable). From the next cycle the two override outputs follow bits 9 and 8. All other register bits read as zero.
- R3: A trigger accepted while idle starts nine clock pulses on the next cycle. Each pulse is STEP_CYC cycles with both lines released, then STEP_CYC cycles with only the clock forced low. The data override stays released throughout.
- R4: After the ninth pulse the stop is built in three phases, each STEP_CYC cycles long. First both lines are forced low, then only data is forced low, then both are released.
- R5: Done is high for exactly one cycle, directly after the last stop phase. From that cycle on, both override bits of the register are cleared, so both lines stay released.
- R6: A trigger that arrives while a sequence is running is ignored. The sequence keeps its length and produces a single done pulse.
- R7: Software writes to the override bits while the sequence is running do not affect the override outputs, and they are not kept after the sequence ends.
- R8: The interrupt enable output always equals register bit 6. Writes to that bit take effect on the next cycle, even while a sequence is running.
- R9: The sequence overrides any pre-set software forcing. Its first phase releases both lines even if software had forced them low before the trigger.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | REG_W | Register write data |
| reg_rdata | output | REG_W | Register read value (live override state and interrupt enable) |
| recover_go | input | 1 | Recovery trigger, sampled when idle |
| recover_done | output | 1 | One-cycle pulse at end of recovery |
| scl_force_low | output | 1 | Drive clock pad low when high |
| sda_force_low | output | 1 | Drive data pad low when high |
| core_irq_en | output | 1 | Core interrupt enable |

## Verification
The bench builds two copies. The main copy uses a step length of 3 cycles, an odd value that shows off-by-one errors in the phase timer, and the full nine pulses. It carries every register, retrigger and blocked-write scenario. A second copy with a step length of 1 selects the counterless timer variant, where every phase lasts a single cycle and the phase changes happen back to back. Its whole 21-cycle trace and done pulse are compared cycle by cycle.

// File: rtl/twl_unstick_pkg.sv
package twl_unstick_pkg;

   // Sequencer phases. One pulse is RELEASE followed by CLKLOW.
   typedef enum logic [2:0] {
      PH_IDLE      = 3'd0,
      PH_RELEASE   = 3'd1,
      PH_CLKLOW    = 3'd2,
      PH_STOP_BOTH = 3'd3,
      PH_STOP_SDA  = 3'd4,
      PH_STOP_FREE = 3'd5
   } phase_t;

   function automatic logic phase_drives_scl(phase_t p);
      return (p == PH_CLKLOW) || (p == PH_STOP_BOTH);
   endfunction

   function automatic logic phase_drives_sda(phase_t p);
      return (p == PH_STOP_BOTH) || (p == PH_STOP_SDA);
   endfunction

endpackage

// File: rtl/twl_step_timer.sv
module twl_step_timer #(
   parameter int STEP_CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   generate
      if (STEP_CYC == 1) begin : g_single
         // Every phase lasts one cycle: no counter required.
         assign tick = run;
      end else begin : g_count
         localparam int CNT_W = $clog2(STEP_CYC);
         localparam logic [CNT_W-1:0] LAST = CNT_W'(STEP_CYC - 1);
         logic [CNT_W-1:0] cnt_q;

         assign tick = run && (cnt_q == LAST);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (!run || tick) begin
               cnt_q <= '0;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/twl_pulse_counter.sv
module twl_pulse_counter #(
   parameter int PULSES = 9
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic inc,
   output logic last
);
   localparam int PC_W = (PULSES > 1) ? $clog2(PULSES) : 1;
   localparam logic [PC_W-1:0] LAST_IDX = PC_W'(PULSES - 1);

   logic [PC_W-1:0] cnt_q;

   assign last = (cnt_q == LAST_IDX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr) begin
         cnt_q <= '0;
      end else if (inc) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/twl_phase_fsm.sv
module twl_phase_fsm
   import twl_unstick_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   go,
   input  logic   tick,
   input  logic   last_pulse,
   output phase_t phase,
   output logic   pulse_inc,
   output logic   seq_end,
   output logic   done
);
   phase_t phase_q, phase_d;
   logic   done_q;

   assign phase     = phase_q;
   assign done      = done_q;
   assign pulse_inc = tick && (phase_q == PH_CLKLOW) && !last_pulse;
   assign seq_end   = tick && (phase_q == PH_STOP_FREE);

   always_comb begin
      phase_d = phase_q;
      unique case (phase_q)
         PH_IDLE:      if (go)   phase_d = PH_RELEASE;
         PH_RELEASE:   if (tick) phase_d = PH_CLKLOW;
         PH_CLKLOW:    if (tick) phase_d = last_pulse ? PH_STOP_BOTH : PH_RELEASE;
         PH_STOP_BOTH: if (tick) phase_d = PH_STOP_SDA;
         PH_STOP_SDA:  if (tick) phase_d = PH_STOP_FREE;
         PH_STOP_FREE: if (tick) phase_d = PH_IDLE;
         default:                phase_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         done_q  <= 1'b0;
      end else begin
         phase_q <= phase_d;
         done_q  <= seq_end;
      end
   end
endmodule

// File: rtl/twl_override_reg.sv
module twl_override_reg (
   input  logic clk,
   input  logic rst_n,
   input  logic we,
   input  logic wr_irq_en,
   input  logic wr_sda,
   input  logic wr_scl,
   input  logic lock,
   input  logic clear_ovr,
   output logic irq_en,
   output logic sw_sda,
   output logic sw_scl
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_en <= 1'b0;
         sw_sda <= 1'b0;
         sw_scl <= 1'b0;
      end else begin
         if (we) begin
            irq_en <= wr_irq_en;
         end
         if (clear_ovr) begin
            sw_sda <= 1'b0;
            sw_scl <= 1'b0;
         end else if (we && !lock) begin
            sw_sda <= wr_sda;
            sw_scl <= wr_scl;
         end
      end
   end
endmodule

// File: rtl/twl_unstick.sv
module twl_unstick
   import twl_unstick_pkg::*;
#(
   parameter int REG_W      = 16,
   parameter int STEP_CYC   = 4,
   parameter int PULSES     = 9,
   parameter int IRQ_EN_BIT = 6,
   parameter int SDA_BIT    = 8,
   parameter int SCL_BIT    = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_we,
   input  logic [REG_W-1:0] reg_wdata,
   output logic [REG_W-1:0] reg_rdata,
   input  logic             recover_go,
   output logic             recover_done,
   output logic             scl_force_low,
   output logic             sda_force_low,
   output logic             core_irq_en
);
   // Elaboration-time parameter checks
   generate
      if (STEP_CYC < 1) begin : g_bad_step
         $error("twl_unstick: STEP_CYC must be at least 1");
      end
      if (PULSES < 1) begin : g_bad_pulses
         $error("twl_unstick: PULSES must be at least 1");
      end
      if (IRQ_EN_BIT >= REG_W || SDA_BIT >= REG_W || SCL_BIT >= REG_W) begin : g_bad_pos
         $error("twl_unstick: a field position lies outside REG_W");
      end
      if (IRQ_EN_BIT == SDA_BIT || IRQ_EN_BIT == SCL_BIT || SDA_BIT == SCL_BIT) begin : g_bad_overlap
         $error("twl_unstick: field positions must be distinct");
      end
   endgenerate

   phase_t phase;
   logic   tick, last_pulse, pulse_inc, seq_end;
   logic   seq_active;
   logic   sw_sda, sw_scl;
   logic   unused_wdata;

   assign seq_active   = (phase != PH_IDLE);
   assign unused_wdata = ^reg_wdata;

   twl_step_timer #(.STEP_CYC(STEP_CYC)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (seq_active),
      .tick  (tick)
   );

   twl_pulse_counter #(.PULSES(PULSES)) u_pulses (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (!seq_active),
      .inc   (pulse_inc),
      .last  (last_pulse)
   );

   twl_phase_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .go         (recover_go),
      .tick       (tick),
      .last_pulse (last_pulse),
      .phase      (phase),
      .pulse_inc  (pulse_inc),
      .seq_end    (seq_end),
      .done       (recover_done)
   );

   twl_override_reg u_reg (
      .clk       (clk),
      .rst_n     (rst_n),
      .we        (reg_we),
      .wr_irq_en (reg_wdata[IRQ_EN_BIT]),
      .wr_sda    (reg_wdata[SDA_BIT]),
      .wr_scl    (reg_wdata[SCL_BIT]),
      .lock      (seq_active),
      .clear_ovr (seq_end),
      .irq_en    (core_irq_en),
      .sw_sda    (sw_sda),
      .sw_scl    (sw_scl)
   );

   assign scl_force_low = seq_active ? phase_drives_scl(phase) : sw_scl;
   assign sda_force_low = seq_active ? phase_drives_sda(phase) : sw_sda;

   always_comb begin
      for (int i = 0; i < REG_W; i++) begin
         if (i == IRQ_EN_BIT)   reg_rdata[i] = core_irq_en;
         else if (i == SDA_BIT) reg_rdata[i] = sda_force_low;
         else if (i == SCL_BIT) reg_rdata[i] = scl_force_low;
         else                   reg_rdata[i] = 1'b0;
      end
   end
endmodule

// File: rtl/twl_unstick_chk.sv
module twl_unstick_chk #(
   parameter int REG_W      = 16,
   parameter int IRQ_EN_BIT = 6,
   parameter int SDA_BIT    = 8,
   parameter int SCL_BIT    = 9
) (
   input logic             clk,
   input logic             rst_n,
   input logic             reg_we,
   input logic [REG_W-1:0] reg_wdata,
   input logic             recover_go,
   input logic             recover_done,
   input logic             scl_force_low,
   input logic             sda_force_low,
   input logic             core_irq_en,
   input logic             seq_active
);
   logic rst_seen_q;
   always_ff @(posedge clk) rst_seen_q <= !rst_n;

   // R1
   always @(negedge clk) begin
      if (!rst_n && rst_seen_q) begin
         reset_quiet_chk: assert (!scl_force_low && !sda_force_low && !recover_done && !core_irq_en)
            else $error("outputs not quiet in reset");
      end
   end

   // R5
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      recover_done |=> !recover_done);

   // R5
   done_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
      recover_done |-> (!seq_active && !scl_force_low && !sda_force_low));

   // R6
   no_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      seq_active |=> (seq_active || recover_done));

   // R3
   no_spurious_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!seq_active && !recover_go) |=> !seq_active);

   // R2
   sw_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!seq_active && reg_we && !recover_go) |=>
         (scl_force_low == $past(reg_wdata[SCL_BIT]) && sda_force_low == $past(reg_wdata[SDA_BIT])));

   // R8
   irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |=> (core_irq_en == $past(reg_wdata[IRQ_EN_BIT])));
endmodule

bind twl_unstick twl_unstick_chk #(
   .REG_W      (REG_W),
   .IRQ_EN_BIT (IRQ_EN_BIT),
   .SDA_BIT    (SDA_BIT),
   .SCL_BIT    (SCL_BIT)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .reg_we        (reg_we),
   .reg_wdata     (reg_wdata),
   .recover_go    (recover_go),
   .recover_done  (recover_done),
   .scl_force_low (scl_force_low),
   .sda_force_low (sda_force_low),
   .core_irq_en   (core_irq_en),
   .seq_active    (seq_active)
);

// File: tb/twl_unstick_test.sv
module twl_unstick_test;
   localparam int REG_W  = 16;
   localparam int STEP   = 3;
   localparam int PULSES = 9;
   localparam int PHASES = 2 * PULSES + 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic             reg_we = 1'b0;
   logic [REG_W-1:0] reg_wdata = '0;
   logic [REG_W-1:0] reg_rdata;
   logic             go = 1'b0;
   logic             done, scl, sda, irq;

   logic             go1 = 1'b0;
   logic [REG_W-1:0] rdata1;
   logic             done1, scl1, sda1, irq1;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   twl_unstick #(.REG_W(REG_W), .STEP_CYC(STEP), .PULSES(PULSES)) uut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .recover_go(go), .recover_done(done),
      .scl_force_low(scl), .sda_force_low(sda), .core_irq_en(irq)
   );

   twl_unstick #(.REG_W(REG_W), .STEP_CYC(1), .PULSES(PULSES)) uut_fast (
      .clk(clk), .rst_n(rst_n), .reg_we(1'b0), .reg_wdata('0),
      .reg_rdata(rdata1), .recover_go(go1), .recover_done(done1),
      .scl_force_low(scl1), .sda_force_low(sda1), .core_irq_en(irq1)
   );

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // Expected pattern at cycle c after the trigger was accepted.
   task automatic expect_at(int c, int step, output logic s, output logic d,
                            output logic dn, output string req);
      int p;
      p = c / step;
      dn = 1'b0; s = 1'b0; d = 1'b0;
      if (c >= PHASES * step) begin
         req = "R5"; dn = (c == PHASES * step);
      end else if (p < 2 * PULSES) begin
         req = "R3"; s = p[0];
      end else if (p == 2 * PULSES) begin
         req = "R4"; s = 1'b1; d = 1'b1;
      end else if (p == 2 * PULSES + 1) begin
         req = "R4"; d = 1'b1;
      end else begin
         req = "R4";
      end
   endtask

   task automatic write_reg(logic [REG_W-1:0] v);
      reg_wdata = v; reg_we = 1'b1;
      @(negedge clk);
      reg_we = 1'b0; reg_wdata = '0;
   endtask

   task automatic t_reset();
      check("R1 scl", scl, 0);
      check("R1 sda", sda, 0);
      check("R1 done", done, 0);
      check("R1 irq", irq, 0);
      check("R1 rdata", reg_rdata, 0);
   endtask

   task automatic t_sw_write();
      write_reg(16'hFFFF);
      check("R2 rdata all ones", reg_rdata, 16'h0340);
      check("R2 scl", scl, 1);
      check("R2 sda", sda, 1);
      check("R8 irq", irq, 1);
      write_reg(16'h0100);
      check("R2 sda only", {scl, sda}, 2'b01);
      check("R8 irq cleared", irq, 0);
      write_reg(16'h0200);
      check("R2 scl only", {scl, sda}, 2'b10);
      write_reg(16'h0000);
      check("R2 cleared", reg_rdata, 0);
   endtask

   // Full trace on main instance; options add retriggers and writes.
   task automatic t_recover(bit retrig, bit sw_mid, bit preset);
      logic es, ed, edn;
      string req;
      if (preset) begin
         write_reg(16'h0300);
         check("R9 preset forced", {scl, sda}, 2'b11);
      end
      go = 1'b1;
      @(negedge clk);
      go = 1'b0;
      for (int c = 0; c <= PHASES * STEP + 3 * STEP; c++) begin
         expect_at(c, STEP, es, ed, edn, req);
         if (preset && c == 0) req = "R9";
         if (sw_mid && c > 7 && c < PHASES * STEP) req = {req, "/R7"};
         if (retrig && c > 4) req = {req, "/R6"};
         check({req, " scl"}, scl, es);
         check({req, " sda"}, sda, ed);
         check({req, " done"}, done, edn);
         go = retrig && (c == 4 || c == PHASES * STEP - 1);
         if (sw_mid && c == 7) begin
            reg_wdata = 16'h0340; reg_we = 1'b1;
         end else begin
            reg_we = 1'b0; reg_wdata = '0;
         end
         @(negedge clk);
      end
      go = 1'b0;
      if (sw_mid) begin
         check("R8 irq kept after mid write", irq, 1);
         check("R7 override field cleared", reg_rdata & 16'h0300, 0);
         write_reg(16'h0000);
         check("R8 irq cleared", irq, 0);
      end
   endtask

   task automatic t_fast();
      logic es, ed, edn;
      string req;
      go1 = 1'b1;
      @(negedge clk);
      go1 = 1'b0;
      for (int c = 0; c <= PHASES + 2; c++) begin
         expect_at(c, 1, es, ed, edn, req);
         check({req, " fast scl"}, scl1, es);
         check({req, " fast sda"}, sda1, ed);
         check({req, " fast done"}, done1, edn);
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_sw_write();
      t_recover(0, 0, 0);
      t_recover(1, 0, 0);
      t_recover(0, 1, 0);
      t_recover(0, 0, 1);
      t_fast();
      if (!finished) begin
         finished = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule